// File: doc/BRIEF.md
# Byte FIFO with Flush and Clear Control

This block buffers bytes in a small first-in first-out store and gives software one control byte to empty that store. Software can either drain the buffered bytes out to a memory-side write port, or throw them away. A drain starts at an address loaded beforehand through a separate load port. Each accepted byte moves the address one step. A direction input chooses whether the step is up or down.

The same control byte carries a fixed revision nibble and a spare read/write bit. It also holds a mode bit that shapes an instruction-fetch strobe. With the mode bit clear, the strobe follows every fetch bus cycle. With it set, the strobe follows only the opcode part of a fetch, and stays low during indirect and table-indirect reads.

Other logic pushes bytes in and pops them out through a plain push/pop interface. The empty, full and count flags remain usable at all times, including during a drain.

Top module: `dma_fifo_flush_ctrl`

## Requirements
- R1: After synchronous reset the control byte reads {REV, 4'b0001}. The FIFO is empty with count 0, and `mem_valid`, `fetch_strobe` and `pop_data` are 0.
- R2: Control byte bits [7:4] always read the REV parameter, and writes to them have no effect. Bit 1 (fetch mode) and bit 0 (spare) read back the value last written to them.
- R3: Bytes leave the FIFO in the order they were pushed. A push is accepted when `push_valid` and `push_ready` are both high, and `push_ready` is low when the FIFO is full. `pop_data` loads the head byte on the clock edge of a pop with `pop_en` high, and otherwise keeps its value. A pop while empty is ignored.
- R4: While bit 3 (flush) reads 1 and the FIFO is not empty, `mem_valid` is high and `mem_data` shows the head byte. Each edge with `mem_valid` and `mem_ready` high removes one byte. The first byte goes to the most recently loaded address.
- R5: Each accepted drain byte moves `mem_addr` by +1 when `addr_down` is 0 and by -1 when it is 1, using the value of `addr_down` in the accepting cycle. A load through `addr_ld` takes priority over the step.
- R6: Bit 3 stays 1 after the FIFO has emptied, until software writes it to 0. After such a write, `mem_valid` is low and the remaining bytes stay in the FIFO.
- R7: During a drain, `fifo_count` falls by one for each accepted byte, and `fifo_empty` rises when the last byte is accepted.
- R8: `push_ready` is low while bit 3 reads 1, and pushes tried then are not stored.
- R9: Writing 1 to bit 2 (clear) makes bit 2 read 1 for exactly one cycle, during which pushes are refused. At the next edge bit 2 returns to 0, the count drops to 0 and all buffered bytes are discarded.
- R10: A clear does not change `pop_data`.
- R11: When flush and clear are written as 1 in the same write, no byte is offered on the memory port. The flush bit still reads 1 afterwards.
- R12: `fetch_strobe` is registered, so it follows its inputs one clock later. With bit 1 at 0 it equals `fetch_cycle`. With bit 1 at 1 it equals `fetch_cycle & fetch_opcode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control byte write strobe |
| reg_wr_data | input | 8 | Control byte write value |
| reg_rd_data | output | 8 | Control byte read value |
| addr_ld | input | 1 | Load drain start address |
| addr_ld_val | input | ADDR_W | Address to load |
| addr_down | input | 1 | Drain address step direction (1 = decrement) |
| push_valid | input | 1 | Push request |
| push_data | input | DATA_W | Byte to push |
| push_ready | output | 1 | Push can be accepted |
| pop_en | input | 1 | Pop request |
| pop_data | output | DATA_W | Registered byte from the last pop |
| fifo_empty | output | 1 | FIFO empty flag |
| fifo_full | output | 1 | FIFO full flag |
| fifo_count | output | clog2(DEPTH+1) | Bytes buffered |
| mem_valid | output | 1 | Drain byte offered |
| mem_ready | input | 1 | Memory side accepts the offered byte |
| mem_addr | output | ADDR_W | Drain byte address |
| mem_data | output | DATA_W | Drain byte |
| fetch_cycle | input | 1 | A fetch bus cycle is in progress |
| fetch_opcode | input | 1 | The cycle is the opcode part of the fetch |
| fetch_strobe | output | 1 | Registered fetch strobe |

## Verification
The hardest cases to reach from the ports are a clear in the same write as a flush while bytes are still buffered, and a drain under back-pressure whose step direction changes from beat to beat. The stimulus first fills the FIFO through random push/pop traffic. It then runs drains with random `mem_ready` and a random `addr_down` on every beat, and stops one of them part-way with a software write. Finally it fires clear alone and clear together with flush, against a pre-filled FIFO and a known `pop_data`.

// File: rtl/dffc_pkg.sv
package dffc_pkg;
  localparam int CTRL_W    = 8;
  localparam int BIT_FLUSH = 3;
  localparam int BIT_CLR   = 2;
  localparam int BIT_MODE  = 1;
  localparam int BIT_SPARE = 0;

  typedef struct packed {
    logic flush;
    logic clr;
    logic mode;
    logic spare;
  } ctrl_lo_t;

  localparam ctrl_lo_t CTRL_RST = '{flush: 1'b0, clr: 1'b0, mode: 1'b0, spare: 1'b1};
endpackage

// File: rtl/dffc_ctrl_reg.sv
module dffc_ctrl_reg
  import dffc_pkg::*;
#(
  parameter logic [3:0] REV = 4'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              flush_on,
  output logic              clr_on,
  output logic              fetch_mode
);
  logic [3:0] rev_q;
  ctrl_lo_t   lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rev_q <= REV;
      lo_q  <= CTRL_RST;
    end else begin
      // clear bit lives exactly one cycle unless rewritten
      lo_q.clr <= wr_en & wr_data[BIT_CLR];
      if (wr_en) begin
        lo_q.flush <= wr_data[BIT_FLUSH];
        lo_q.mode  <= wr_data[BIT_MODE];
        lo_q.spare <= wr_data[BIT_SPARE];
      end
    end
  end

  assign rd_data    = {rev_q, lo_q};
  assign flush_on   = lo_q.flush;
  assign clr_on     = lo_q.clr;
  assign fetch_mode = lo_q.mode;

  AST_REV_FIXED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7:4] != REV) |=> rd_data[7:4] == REV); // R2
  AST_CLR_SELF: assert property (@(posedge clk) disable iff (rst)
    (rd_data[BIT_CLR] && !(wr_en && wr_data[BIT_CLR])) |=> !rd_data[BIT_CLR]); // R9
  AST_FLUSH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rd_data[BIT_FLUSH] && !wr_en) |=> rd_data[BIT_FLUSH]); // R6
endmodule

// File: rtl/dffc_fifo.sv
module dffc_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hold,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_din,
  output logic              push_ready,
  input  logic              pop_req,
  input  logic              drain,
  output logic [DATA_W-1:0] pop_data,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              push_ok, user_ok, take;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty      = (count == '0);
  assign full       = (count == CW'(DEPTH));
  assign push_ready = !full && !hold;
  assign push_ok    = push_req && push_ready;
  assign user_ok    = pop_req && !empty && !hold;
  assign take       = user_ok || drain;
  assign head       = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (take)    rd_ptr <= nxt(rd_ptr);
      if (push_ok && !take)      count <= count + CW'(1);
      else if (take && !push_ok) count <= count - CW'(1);
    end
  end

  // output word is left alone by a clear
  always_ff @(posedge clk) begin
    if (rst)          pop_data <= '0;
    else if (user_ok) pop_data <= store[rd_ptr];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R3
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && empty)); // R9
  AST_CLR_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
    clr |=> $stable(pop_data)); // R10
  AST_DRAIN_COUNT: assert property (@(posedge clk) disable iff (rst)
    (drain && !push_ok && !clr) |=> count == $past(count) - CW'(1)); // R7
endmodule

// File: rtl/dffc_flush_eng.sv
module dffc_flush_eng #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] head,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_ld_val,
  input  logic              addr_down,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              drain
);
  logic [ADDR_W-1:0] cur_addr;

  assign mem_valid = go && !fifo_empty;
  assign drain     = mem_valid && mem_ready;
  assign mem_addr  = cur_addr;
  assign mem_data  = head;

  always_ff @(posedge clk) begin
    if (rst)          cur_addr <= '0;
    else if (addr_ld) cur_addr <= addr_ld_val;
    else if (drain)   cur_addr <= addr_down ? cur_addr - ADDR_W'(1) : cur_addr + ADDR_W'(1);
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !addr_ld) |=>
      mem_addr == ($past(addr_down) ? $past(mem_addr) - ADDR_W'(1)
                                    : $past(mem_addr) + ADDR_W'(1))); // R5
endmodule

// File: rtl/dffc_fetch_gate.sv
module dffc_fetch_gate (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic fetch_cycle,
  input  logic fetch_opcode,
  output logic strobe
);
  always_ff @(posedge clk) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= fetch_cycle && (!mode || fetch_opcode);
  end

  AST_FETCH_OPC: assert property (@(posedge clk) disable iff (rst)
    (mode && !fetch_opcode) |=> !strobe); // R12
endmodule

// File: rtl/dma_fifo_flush_ctrl.sv
module dma_fifo_flush_ctrl
  import dffc_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter int         DEPTH  = 16,
  parameter int         ADDR_W = 32,
  parameter logic [3:0] REV    = 4'h2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr_en,
  input  logic [CTRL_W-1:0]            reg_wr_data,
  output logic [CTRL_W-1:0]            reg_rd_data,
  input  logic                         addr_ld,
  input  logic [ADDR_W-1:0]            addr_ld_val,
  input  logic                         addr_down,
  input  logic                         push_valid,
  input  logic [DATA_W-1:0]            push_data,
  output logic                         push_ready,
  input  logic                         pop_en,
  output logic [DATA_W-1:0]            pop_data,
  output logic                         fifo_empty,
  output logic                         fifo_full,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_count,
  output logic                         mem_valid,
  input  logic                         mem_ready,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_data,
  input  logic                         fetch_cycle,
  input  logic                         fetch_opcode,
  output logic                         fetch_strobe
);
  logic              flush_on, clr_on, fetch_mode, drain;
  logic [DATA_W-1:0] head;

  dffc_ctrl_reg #(.REV(REV)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .rd_data(reg_rd_data), .flush_on(flush_on), .clr_on(clr_on),
    .fetch_mode(fetch_mode)
  );

  dffc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(clr_on), .hold(flush_on | clr_on),
    .push_req(push_valid), .push_din(push_data), .push_ready(push_ready),
    .pop_req(pop_en), .drain(drain), .pop_data(pop_data), .head(head),
    .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
  );

  dffc_flush_eng #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_flush (
    .clk(clk), .rst(rst), .go(flush_on & ~clr_on), .fifo_empty(fifo_empty),
    .head(head), .addr_ld(addr_ld), .addr_ld_val(addr_ld_val),
    .addr_down(addr_down), .mem_ready(mem_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .drain(drain)
  );

  dffc_fetch_gate u_fetch (
    .clk(clk), .rst(rst), .mode(fetch_mode), .fetch_cycle(fetch_cycle),
    .fetch_opcode(fetch_opcode), .strobe(fetch_strobe)
  );

  AST_PUSH_BLOCK: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[BIT_FLUSH] |-> !push_ready); // R8
  AST_CLR_NO_DRAIN: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[BIT_CLR] |-> !mem_valid); // R11
endmodule

// File: tb/tb_dma_fifo_flush_ctrl.sv
module tb_dma_fifo_flush_ctrl;
  localparam int         DATA_W = 8;
  localparam int         DEPTH  = 16;
  localparam int         ADDR_W = 32;
  localparam logic [3:0] REV    = 4'h2;
  localparam int         CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic addr_ld = 1'b0;
  logic [ADDR_W-1:0] addr_ld_val = '0;
  logic addr_down = 1'b0;
  logic push_valid = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic push_ready;
  logic pop_en = 1'b0;
  logic [DATA_W-1:0] pop_data;
  logic fifo_empty, fifo_full;
  logic [CW-1:0] fifo_count;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic fetch_cycle = 1'b0;
  logic fetch_opcode = 1'b0;
  logic fetch_strobe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] q[$];
  logic [7:0] exp_pd = '0;
  logic [ADDR_W-1:0] exp_addr = '0;

  always #5 clk = ~clk;

  dma_fifo_flush_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .REV(REV)) dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .addr_ld(addr_ld), .addr_ld_val(addr_ld_val),
    .addr_down(addr_down), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_en(pop_en), .pop_data(pop_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .fetch_cycle(fetch_cycle), .fetch_opcode(fetch_opcode),
    .fetch_strobe(fetch_strobe)
  );

  function automatic logic [7:0] exp_reg(input logic f, input logic c, input logic m, input logic s);
    return {REV, f, c, m, s};
  endfunction

  function automatic logic exp_strobe(input logic m, input logic cyc, input logic opc);
    return cyc && (!m || opc);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_wr_en = 1'b1;
    reg_wr_data = v;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] d);
    push_valid = 1'b1;
    push_data = d;
    step();
    push_valid = 1'b0;
    q.push_back(d);
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " count"}, fifo_count, q.size());
    chk({tag, " empty"}, fifo_empty, q.size() == 0);
    chk({tag, " full"}, fifo_full, q.size() == DEPTH);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;

    // R1 reset state
    chk("R1 reg", reg_rd_data, exp_reg(0, 0, 0, 1));
    chk_flags("R1");
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 strobe", fetch_strobe, 0);
    chk("R1 pop_data", pop_data, 0);

    // R2 directed: upper nibble write ignored
    wr_reg(8'hF2);
    chk("R2 reg F2", reg_rd_data, exp_reg(0, 0, 1, 0));
    wr_reg(8'h51);
    chk("R2 reg 51", reg_rd_data, exp_reg(0, 0, 0, 1));

    // R12 fetch strobe, random mode and inputs
    for (int i = 0; i < 40; i++) begin
      logic m, fc, fo;
      logic [3:0] nib;
      m = 1'($urandom % 2);
      nib = 4'($urandom);
      wr_reg({nib, 2'b00, m, 1'b1});
      chk("R2 reg rand", reg_rd_data, exp_reg(0, 0, m, 1));
      fc = 1'($urandom % 2);
      fo = 1'($urandom % 2);
      fetch_cycle = fc;
      fetch_opcode = fo;
      step();
      chk("R12 strobe", fetch_strobe, exp_strobe(m, fc, fo));
    end
    fetch_cycle = 1'b0;
    fetch_opcode = 1'b0;
    wr_reg(8'h01);

    // R3 random push/pop against a queue model
    for (int i = 0; i < 300; i++) begin
      logic pv, pe;
      logic [7:0] d;
      int sz;
      pv = (i < 150) ? (($urandom % 10) < 7) : (($urandom % 10) < 3);
      pe = (i < 150) ? (($urandom % 10) < 3) : (($urandom % 10) < 7);
      d = 8'($urandom);
      push_valid = pv;
      push_data = d;
      pop_en = pe;
      chk("R3 push_ready", push_ready, q.size() < DEPTH);
      sz = q.size();
      step();
      if (pe && sz > 0) exp_pd = q.pop_front();
      if (pv && sz < DEPTH) q.push_back(d);
      chk_flags("R3");
      chk("R3 pop_data", pop_data, exp_pd);
    end
    push_valid = 1'b0;
    pop_en = 1'b0;

    // R4 R5 R7 R8 drain upward with back-pressure
    while (q.size() < 8) push_byte(8'($urandom));
    addr_ld = 1'b1;
    addr_ld_val = 32'h0000_1000;
    step();
    addr_ld = 1'b0;
    exp_addr = 32'h0000_1000;
    wr_reg(8'h09);
    for (int i = 0; i < 80; i++) begin
      logic rdy;
      logic v;
      v = (q.size() != 0);
      chk("R4 mem_valid", mem_valid, v);
      if (v) begin
        chk("R4 mem_data", mem_data, q[0]);
        chk("R5 mem_addr up", mem_addr, exp_addr);
      end
      chk("R8 push_ready", push_ready, 0);
      chk_flags("R7");
      rdy = (($urandom % 4) != 0);
      mem_ready = rdy;
      addr_down = 1'b0;
      push_valid = 1'b1;
      push_data = 8'($urandom);
      step();
      if (v && rdy) begin
        void'(q.pop_front());
        exp_addr = exp_addr + 1;
      end
    end
    push_valid = 1'b0;
    mem_ready = 1'b1;
    chk("R6 flush sticky", reg_rd_data, exp_reg(1, 0, 0, 1));
    chk("R7 empty after drain", fifo_empty, 1);
    step();
    chk("R6 idle valid", mem_valid, 0);
    mem_ready = 1'b0;

    // R5 R6 drain with per-beat direction, stopped part-way
    wr_reg(8'h01);
    while (q.size() < 10) push_byte(8'($urandom));
    addr_ld = 1'b1;
    addr_ld_val = 32'h0000_2005;
    step();
    addr_ld = 1'b0;
    exp_addr = 32'h0000_2005;
    wr_reg(8'h09);
    for (int i = 0; i < 500 && q.size() > 3; i++) begin
      logic rdy, dn;
      chk("R4 mem_valid 2", mem_valid, 1);
      chk("R4 mem_data 2", mem_data, q[0]);
      chk("R5 mem_addr mixed", mem_addr, exp_addr);
      rdy = 1'($urandom % 2);
      dn = 1'($urandom % 2);
      mem_ready = rdy;
      addr_down = dn;
      step();
      if (rdy) begin
        void'(q.pop_front());
        exp_addr = dn ? exp_addr - 1 : exp_addr + 1;
      end
    end
    mem_ready = 1'b0;
    wr_reg(8'h01);
    chk("R6 stop valid", mem_valid, 0);
    chk("R6 stop reg", reg_rd_data, exp_reg(0, 0, 0, 1));
    chk_flags("R6 stop");
    mem_ready = 1'b1;
    step();
    chk("R6 stop valid 2", mem_valid, 0);
    chk_flags("R6 kept");
    mem_ready = 1'b0;

    // R9 R10 clear
    pop_en = 1'b1;
    step();
    pop_en = 1'b0;
    exp_pd = q.pop_front();
    chk("R3 pop before clear", pop_data, exp_pd);
    wr_reg(8'h05);
    chk("R9 clr reads 1", reg_rd_data, exp_reg(0, 1, 0, 1));
    chk("R9 push_ready in clr", push_ready, 0);
    push_valid = 1'b1;
    push_data = 8'h77;
    step();
    push_valid = 1'b0;
    q.delete();
    chk("R9 clr self", reg_rd_data, exp_reg(0, 0, 0, 1));
    chk_flags("R9");
    chk("R10 pop_data kept", pop_data, exp_pd);
    push_byte(8'hA5);
    pop_en = 1'b1;
    step();
    pop_en = 1'b0;
    exp_pd = q.pop_front();
    chk("R9 fresh data", pop_data, 8'hA5);
    chk_flags("R9 after");

    // R11 clear and flush together
    push_byte(8'h11);
    push_byte(8'h22);
    push_byte(8'h33);
    mem_ready = 1'b1;
    wr_reg(8'h0D);
    chk("R11 valid in clr", mem_valid, 0);
    chk("R11 reg", reg_rd_data, exp_reg(1, 1, 0, 1));
    step();
    q.delete();
    chk("R11 valid after", mem_valid, 0);
    chk("R11 reg after", reg_rd_data, exp_reg(1, 0, 0, 1));
    chk_flags("R11");
    repeat (3) begin
      step();
      chk("R11 no drain", mem_valid, 0);
    end
    mem_ready = 1'b0;
    wr_reg(8'h01);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule